// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits in the read path of a flash-style memory. It swaps array data for progress information while an internal program or erase runs. A command decoder outside this block supplies a busy flag, the kind of operation and bit 7 of the last value loaded for programming. The block then reports completion in three ways at once. Bit 7 is a polling bit whose meaning depends on the kind of operation. Bit 6 changes value once per completed read access. A pull-low enable drives an open-drain ready line.

Host reads are defined by the active-low chip-select and output-enable strobes, which are sampled on the block clock. A read access begins when both strobes are low. It ends when either strobe rises, and the toggle bit advances at that point. Its value therefore holds still for the whole of an access. After the operation ends, every read returns plain array data, and the ready line is released. A released line lets several devices share one wired-OR ready net.

Top module: `esr_status_reporter`

## Requirements
- R1: While reset is low, and in the first cycle after it, `rdy_pull_en` is 0 and `dout` equals `array_data`. The toggle bit of the first operation after reset starts at 0.
- R2: With no operation running, `dout` equals `array_data` on every read.
- R3: While a program runs (`op_is_erase`=0), a read at `rd_addr == prog_addr` returns the inverse of `prog_poll_bit` on `dout[7]`.
- R4: While a program runs, a read at any other address returns `array_data[7]` on `dout[7]`.
- R5: While an erase runs (`op_is_erase`=1), `dout[7]` is 0 for any address. This holds from the cycle after busy is sampled high.
- R6: While an operation runs, `dout[6]` inverts once at the end of each read access. An access ends when `ce_n` or `oe_n` rises after both were low.
- R7: `dout[6]` keeps its value for as long as an access continues.
- R8: From the cycle after `op_busy` is sampled low, all bits of `dout` equal `array_data`.
- R9: `rdy_pull_en` is 1 in each cycle after `op_busy` is sampled high and 0 in each cycle after it is sampled low. The external pin is driven low only while the enable is 1 and is high impedance otherwise.
- R10: `dout_oe` is 1 only when `ce_n` and `oe_n` are both low.
- R11: While an operation runs, every `dout` bit other than 6 and 7 equals the matching `array_data` bit.
- R12: Each new operation starts with `dout[6]` at 0, whatever the toggle value was in the previous operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_busy | input | 1 | High while an embedded program or erase runs |
| op_is_erase | input | 1 | 1 for a chip or sector erase, 0 for a program |
| prog_addr | input | ADDR_W | Address being programmed |
| prog_poll_bit | input | 1 | Bit 7 of the last value loaded for programming |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | DATA_W | Data read from the array |
| dout | output | DATA_W | Value presented to the data bus |
| dout_oe | output | 1 | Data bus output enable |
| rdy_pull_en | output | 1 | Pull the open-drain ready line low |

## Verification
Three internal state elements can go wrong: a stale busy register, a wrong operation-kind register and a misbehaving toggle flop. A stale busy register keeps status bits on the bus, or the ready line held low, for one or more cycles after completion. That is visible on the first read after busy falls. A wrong operation-kind register flips `dout[7]` on the very first status read. A toggle flop that is not cleared at the start of an operation, or that advances inside an access rather than at its end, shows a wrong `dout[6]`. The error appears on the first read of the new operation, or on the second sample taken during one long access.

// File: rtl/esr_pkg.sv
// Package: shared constants and types for the embedded operation status reporter.
// Assumes the data bus is at least 8 bits wide so that bits 6 and 7 exist.
package esr_pkg;
    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;
endpackage

// File: rtl/esr_access_tracker.sv
// Module: esr_access_tracker
// Registers the busy flag and the operation kind. It also detects when a host
// read access ends. Assumes ce_n and oe_n are synchronous to clk.
module esr_access_tracker
    import esr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ce_n,
    input  logic     oe_n,
    input  logic     op_busy,
    input  logic     op_is_erase,
    output logic     rd_active,
    output logic     acc_end,
    output logic     busy_q,
    output op_kind_e kind_q
);
    logic rd_q;

    // A read access is in progress whenever both strobes are low.
    always_comb rd_active = !ce_n && !oe_n;

    // An access ends in the cycle where it was active last cycle but not now.
    always_comb acc_end = rd_q && !rd_active;

    // Keep a registered copy of the access, busy and kind state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            busy_q <= 1'b0;
            kind_q <= OP_PROGRAM;
        end else begin
            rd_q   <= rd_active;
            busy_q <= op_busy;
            kind_q <= op_is_erase ? OP_ERASE : OP_PROGRAM;
        end
    end
endmodule

// File: rtl/esr_toggle_cell.sv
// Module: esr_toggle_cell
// Holds the toggle bit. It is forced to 0 while idle and in the first busy
// cycle, then inverts at the end of each read access. Assumes busy_q is
// op_busy delayed by one cycle.
module esr_toggle_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic op_busy,
    input  logic busy_q,
    input  logic acc_end,
    output logic tog
);
    // Clear at the start and outside an operation, advance once per access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog <= 1'b0;
        end else if (!op_busy || !busy_q) begin
            tog <= 1'b0;
        end else if (acc_end) begin
            tog <= ~tog;
        end
    end
endmodule

// File: rtl/esr_status_mux.sv
// Module: esr_status_mux
// Builds the read data one bit at a time. Bits 7 and 6 carry status while
// busy, and every other bit passes array data through. Assumes DATA_W >= 8.
module esr_status_mux
    import esr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 18
) (
    input  logic              busy_q,
    input  op_kind_e          kind_q,
    input  logic              tog,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic              prog_poll_bit,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dout
);
    logic addr_hit;
    logic poll_val;

    // The polling bit reports the inverted loaded bit only for the location being programmed.
    always_comb addr_hit = (rd_addr == prog_addr);

    // Erase reads 0, a program read at the target reads inverted data, else array data.
    always_comb begin
        if (kind_q == OP_ERASE) begin
            poll_val = 1'b0;
        end else if (addr_hit) begin
            poll_val = ~prog_poll_bit;
        end else begin
            poll_val = array_data[POLL_BIT];
        end
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == POLL_BIT) begin : g_poll
            // Polling bit select.
            always_comb dout[b] = busy_q ? poll_val : array_data[b];
        end else if (b == TOGGLE_BIT) begin : g_tog
            // Toggle bit select.
            always_comb dout[b] = busy_q ? tog : array_data[b];
        end else begin : g_pass
            // Plain data bit.
            always_comb dout[b] = array_data[b];
        end
    end
endmodule

// File: rtl/esr_status_reporter.sv
// Module: esr_status_reporter (top)
// Read-path status reporter for embedded program and erase operations. It
// drives polling and toggle bits plus an open-drain ready enable. Assumes the
// command decoder holds op_is_erase, prog_addr and prog_poll_bit stable while
// op_busy is high.
module esr_status_reporter
    import esr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_busy,
    input  logic              op_is_erase,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic              prog_poll_bit,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              rdy_pull_en
);
    logic     rd_active;
    logic     acc_end;
    logic     busy_q;
    op_kind_e kind_q;
    logic     tog;

    esr_access_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .op_busy    (op_busy),
        .op_is_erase(op_is_erase),
        .rd_active  (rd_active),
        .acc_end    (acc_end),
        .busy_q     (busy_q),
        .kind_q     (kind_q)
    );

    esr_toggle_cell u_tog (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_busy(op_busy),
        .busy_q (busy_q),
        .acc_end(acc_end),
        .tog    (tog)
    );

    esr_status_mux #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_mux (
        .busy_q       (busy_q),
        .kind_q       (kind_q),
        .tog          (tog),
        .rd_addr      (rd_addr),
        .prog_addr    (prog_addr),
        .prog_poll_bit(prog_poll_bit),
        .array_data   (array_data),
        .dout         (dout)
    );

    // Bus enable follows the active read access.
    always_comb dout_oe = rd_active;

    // Ready line is pulled low for exactly the registered busy window.
    always_comb rdy_pull_en = busy_q;
endmodule

// File: rtl/esr_status_checker.sv
// Module: esr_status_checker
// Port-level properties of the status reporter, attached by bind.
module esr_status_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_busy,
    input logic              op_is_erase,
    input logic              ce_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic              rdy_pull_en
);
    // Ready line follows busy one cycle later (R9).
    assert_rdy_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy |=> rdy_pull_en);
    assert_rdy_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_busy |=> !rdy_pull_en);

    // An erase always polls as 0 (R5).
    assert_erase_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && op_is_erase) |=> (dout[7] == 1'b0));

    // Idle reads return true array data (R8).
    assert_idle_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !op_busy |=> (dout == array_data));

    // A fresh operation starts with the toggle bit at 0 (R12).
    assert_toggle_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_busy) |=> (dout[6] == 1'b0));

    // A deselected bus is never driven (R10).
    always_comb begin
        if (ce_n || oe_n) begin
            assert_bus_off_R10: assert (!dout_oe);
        end
    end
endmodule

bind esr_status_reporter esr_status_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_busy    (op_busy),
    .op_is_erase(op_is_erase),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .array_data (array_data),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .rdy_pull_en(rdy_pull_en)
);

// File: tb/test_esr_status_reporter.sv
// Bench for esr_status_reporter: a vector table walk, then directed reset and corner tests.
module test_esr_status_reporter;
    localparam int DW = 16;
    localparam int AW = 18;
    localparam int NV = 17;
    localparam logic [AW-1:0] PADDR = 18'h00100;

    typedef struct packed {
        logic          busy;
        logic          er;
        logic          ce_n;
        logic          oe_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] arr;
        logic [DW-1:0] exp;
        logic          exp_oe;
        logic          exp_rdy;
    } vec_t;

    // Expected values follow the requirements; each row is applied and then checked one edge later.
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 18'h00100, 16'h1234, 16'h1234, 1'b1, 1'b0}, // R2
        '{1'b0, 1'b0, 1'b1, 1'b1, 18'h00100, 16'h00FF, 16'h00FF, 1'b0, 1'b0}, // R10
        '{1'b1, 1'b0, 1'b1, 1'b1, 18'h00100, 16'h1234, 16'h12B4, 1'b0, 1'b1}, // R9
        '{1'b1, 1'b0, 1'b0, 1'b0, 18'h00100, 16'h1234, 16'h12B4, 1'b1, 1'b1}, // R3
        '{1'b1, 1'b0, 1'b0, 1'b0, 18'h00100, 16'h1234, 16'h12B4, 1'b1, 1'b1}, // R7
        '{1'b1, 1'b0, 1'b1, 1'b1, 18'h00100, 16'h1234, 16'h12F4, 1'b0, 1'b1}, // R6
        '{1'b1, 1'b0, 1'b0, 1'b0, 18'h00100, 16'h1234, 16'h12F4, 1'b1, 1'b1}, // R6
        '{1'b1, 1'b0, 1'b1, 1'b1, 18'h00100, 16'h1234, 16'h12B4, 1'b0, 1'b1}, // R6
        '{1'b1, 1'b0, 1'b0, 1'b0, 18'h00020, 16'h1234, 16'h1234, 1'b1, 1'b1}, // R4
        '{1'b1, 1'b0, 1'b1, 1'b1, 18'h00020, 16'h1234, 16'h1274, 1'b0, 1'b1}, // R11
        '{1'b0, 1'b0, 1'b0, 1'b0, 18'h00100, 16'h1234, 16'h1234, 1'b1, 1'b0}, // R8
        '{1'b1, 1'b1, 1'b0, 1'b0, 18'h00100, 16'h12F4, 16'h1234, 1'b1, 1'b1}, // R5
        '{1'b1, 1'b1, 1'b1, 1'b0, 18'h00100, 16'h12F4, 16'h1274, 1'b0, 1'b1}, // R6
        '{1'b1, 1'b1, 1'b0, 1'b0, 18'h00020, 16'h12F4, 16'h1274, 1'b1, 1'b1}, // R5
        '{1'b1, 1'b1, 1'b0, 1'b1, 18'h00020, 16'h12F4, 16'h1234, 1'b0, 1'b1}, // R10
        '{1'b0, 1'b0, 1'b1, 1'b1, 18'h00020, 16'hABCD, 16'hABCD, 1'b0, 1'b0}, // R9
        '{1'b1, 1'b0, 1'b0, 1'b0, 18'h00100, 16'hABCD, 16'hAB8D, 1'b1, 1'b1}  // R12
    };

    string tags [NV] = '{"R2", "R10", "R9", "R3", "R7", "R6", "R6", "R6", "R4",
                         "R11", "R8", "R5", "R6", "R5", "R10", "R9", "R12"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_busy = 1'b0;
    logic          op_is_erase = 1'b0;
    logic [AW-1:0] prog_addr = PADDR;
    logic          prog_poll_bit = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] array_data = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;
    logic          rdy_pull_en;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    esr_status_reporter #(.DATA_W(DW), .ADDR_W(AW)) i_esr_status_reporter (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_busy      (op_busy),
        .op_is_erase  (op_is_erase),
        .prog_addr    (prog_addr),
        .prog_poll_bit(prog_poll_bit),
        .ce_n         (ce_n),
        .oe_n         (oe_n),
        .rd_addr      (rd_addr),
        .array_data   (array_data),
        .dout         (dout),
        .dout_oe      (dout_oe),
        .rdy_pull_en  (rdy_pull_en)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [DW-1:0] ed, logic eo, logic er);
        n_chk++;
        if (dout !== ed || dout_oe !== eo || rdy_pull_en !== er) begin
            n_bad++;
            $display("FAIL %s: dout=%h oe=%b rdy=%b expected dout=%h oe=%b rdy=%b",
                     tag, dout, dout_oe, rdy_pull_en, ed, eo, er);
        end
    endtask

    initial begin
        // Reset held while an operation is pending (R1).
        op_busy = 1'b1; ce_n = 1'b0; oe_n = 1'b0; rd_addr = PADDR; array_data = 16'hABCD;
        tick(); tick();
        check("R1", 16'hABCD, 1'b1, 1'b0);
        rst_n = 1'b1;
        tick();
        check("R1", 16'hAB8D, 1'b1, 1'b1);
        op_busy = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        tick();

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            op_busy = VEC[i].busy; op_is_erase = VEC[i].er;
            ce_n = VEC[i].ce_n; oe_n = VEC[i].oe_n;
            rd_addr = VEC[i].addr; array_data = VEC[i].arr;
            tick();
            check(tags[i], VEC[i].exp, VEC[i].exp_oe, VEC[i].exp_rdy);
        end

        // Loaded bit 7 = 1 polls as 0 at the target during the same access (R3).
        prog_poll_bit = 1'b1;
        #1;
        check("R3", 16'hAB0D, 1'b1, 1'b1);

        // Reset in the middle of an operation returns array data (R1).
        rst_n = 1'b0;
        tick();
        check("R1", 16'hABCD, 1'b1, 1'b0);
        rst_n = 1'b1;
        op_busy = 1'b0;
        tick();
        check("R8", 16'hABCD, 1'b1, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule